// File: doc/BRIEF.md
# Stop-Mode Wakeup Controller

This block sequences a small microcontroller into and out of two deep-sleep modes. Software raises a stop request together with a depth select. The shallow mode halts the clocks and puts the regulator in standby while all internal state is kept. The deep mode does the same and also freezes the current I/O pin values in hold latches. The controller runs on an always-on wake clock. It watches five wake sources: the reset pin, an IRQ line, two keyboard interrupt groups, and a periodic tick from an external rate divider.

On exit from the shallow mode, the controller requests an interrupt vector with a code that names the source. If the reset pin caused the exit, it requests the reset vector instead. Every exit from the deep mode is treated as a full power-on restart: the controller pulses the reset-vector and peripheral-reset requests and sets a recovery flag. The pins stay frozen, even after that restart, until software writes a 1 to the acknowledge bit. That write opens the latches and clears the flag.

Software reaches the controller through a small register port:

| Address | Contents |
|---|---|
| 0 | Wake configuration |
| 1 | Tick rate select |
| 2 | Acknowledge (write-only strobe) |
| 3 | Read-only status |

Top module: `stopctl_top`

## Requirements
- R1: When the controller enters the deep mode (stop_req with stop_deep=1), it captures the current pin_out value and raises pin_hold. From then on, pin_out keeps the captured value whatever pin_in does.
- R2: A write of 1 to bit 0 at address 2 lowers pin_hold, so pin_out follows pin_in again, and clears the recovery flag (status bit 0). A write of 0 to that bit changes nothing. Address 2 always reads 0.
- R3: The cycle after a stop request is accepted, clk_halt and reg_standby go high. They stay high until a wake is taken. The shallow mode (stop_deep=0) leaves pin_hold low.
- R4: In the deep mode, the following sources wake the device:
  - the reset pin when it is low;
  - IRQ when enabled (config bit 0) and the line is low;
  - keyboard group 1 when enabled (config bit 2) and the line is low;
  - the tick.

  IRQ and group 1 are active-low in this mode whatever their polarity bits say. Keyboard group 2 never wakes the deep mode.
- R5: A deep-mode exit pulses vec_reset and periph_rst for one cycle, does not pulse vec_irq, and sets the recovery flag. pin_hold stays high.
- R6: In the shallow mode, the following sources wake the device:
  - the reset pin when it is low;
  - IRQ, keyboard group 1 or keyboard group 2 when enabled (config bits 0, 2, 4) and at their configured level (config bits 1, 3, 5; 1 = active high);
  - the tick.

  A reset-pin exit pulses vec_reset and periph_rst. Any other exit pulses vec_irq with vec_src set to 1 (IRQ), 2 (group 1), 3 (group 2) or 4 (tick). When several sources are active at once, the priority is reset pin, then IRQ, group 1, group 2, tick.
- R7: While the tick rate select (address 1, bits 2:0) is 000, the tick cannot wake either mode.
- R8: Each wake input passes through a two-flop synchronizer. A change driven before clock edge k takes effect at edge k+2, and the vector pulse is visible after edge k+2.
- R9: Status (address 3) holds the recovery flag in bit 0 and a one-hot record of the last wake source in bits 1 to 5: reset pin, IRQ, group 1, group 2, tick. Writes to address 3 are ignored.
- R10: A stop request made while a wake source of the requested mode is already active is dropped. clk_halt stays low, pin_hold is not raised, and no vector is requested.
- R11: After reset, the controller is in run mode: clk_halt, reg_standby, pin_hold and all vector outputs are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on wake clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | Stop request, one cycle |
| stop_deep | input | 1 | Mode select with stop_req: 1 deep, 0 shallow |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| irq_pin | input | 1 | IRQ line, asynchronous |
| kb1_pin | input | 1 | Keyboard group 1 wake line, asynchronous |
| kb2_pin | input | 1 | Keyboard group 2 wake line, asynchronous |
| tick_pulse | input | 1 | Periodic wake tick from the rate divider |
| pin_in | input | PINS | Values the port logic drives toward the pins |
| pin_out | output | PINS | Values presented at the pins |
| pin_hold | output | 1 | Pin latch closed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| clk_halt | output | 1 | Halt system clocks |
| reg_standby | output | 1 | Regulator standby request |
| vec_reset | output | 1 | Reset-vector start request, one-cycle pulse |
| periph_rst | output | 1 | Peripheral reset, one-cycle pulse |
| vec_irq | output | 1 | Interrupt-vector start request, one-cycle pulse |
| vec_src | output | 3 | Interrupt source code, valid with vec_irq |

## Verification
Some properties are checked by assertions on every cycle:
- the pin latch stays closed and pin_out stays steady until an acknowledge write;
- the deep mode holds while none of its sources is active;
- every deep-mode exit pulses the reset pair and sets the flag;
- the two vector requests are never raised together;
- a stop request made with a wake source already active never halts the clocks.

Other behaviour only the directed scenarios can show:
- the mode-dependent polarity rules;
- that keyboard group 2 is ignored in the deep mode;
- the tick being gated off by rate 000;
- the source codes and their priority;
- the two-cycle synchronizer delay;
- the status encoding and the acknowledge sequence.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_SHALLOW = 2'd1,
        M_DEEP  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        V_NONE = 3'd0,
        V_IRQ  = 3'd1,
        V_KB1  = 3'd2,
        V_KB2  = 3'd3,
        V_TICK = 3'd4
    } vsrc_e;

    localparam int NSRC   = 5;   // reset pin, irq, kb1, kb2, tick
    localparam int TSEL_W = 3;
    localparam int DW     = 8;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_TICK = 2'd1;
    localparam logic [1:0] A_ACK  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

endpackage

// File: rtl/stopctl_sync.sv
module stopctl_sync #(
    parameter int                N       = 5,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/stopctl_pinhold.sv
module stopctl_pinhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_i,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic         hold
);
    typedef struct packed {
        logic         hold;
        logic [W-1:0] val;
    } ph_t;

    ph_t ph_q, ph_d;

    assign pin_out = ph_q.hold ? ph_q.val : pin_in;
    assign hold    = ph_q.hold;

    always_comb begin
        ph_d = ph_q;
        if (release_i) ph_d.hold = 1'b0;
        if (capture) begin
            ph_d.hold = 1'b1;
            ph_d.val  = pin_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // R1: a capture closes the latch on the value the pins showed
    a_r1_capture_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (hold && pin_out == $past(pin_out)));
endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic            stop_deep,
    input  logic            rst_pin_n,
    input  logic            irq_pin,
    input  logic            kb1_pin,
    input  logic            kb2_pin,
    input  logic            tick_pulse,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic            pin_hold,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            clk_halt,
    output logic            reg_standby,
    output logic            vec_reset,
    output logic            periph_rst,
    output logic            vec_irq,
    output logic [2:0]      vec_src
);
    typedef struct packed {
        mode_e             mode;
        logic [DW-1:0]     cfg;
        logic [TSEL_W-1:0] tsel;
        logic              flag;
        logic [NSRC-1:0]   src;
        logic              vrst;
        logic              virq;
        vsrc_e             vsrc;
    } st_t;

    st_t st_q, st_d;

    logic [NSRC-1:0] raw_w, syn_w;
    logic [NSRC-1:0] wake_req, wake_now, first;
    logic            ack_wr, capture;

    assign raw_w = {tick_pulse, kb2_pin, kb1_pin, irq_pin, rst_pin_n};

    stopctl_sync #(.N(NSRC), .RST_VAL(5'b00001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
    );

    // bit order of the result: rst, irq, kb1, kb2, tick (also the priority)
    function automatic logic [NSRC-1:0] wake_set(input logic deep,
                                                 input logic [5:0] c,
                                                 input logic tick_on,
                                                 input logic [NSRC-1:0] s);
        logic [NSRC-1:0] w;
        w[0] = ~s[0];
        w[1] = c[0] & (deep ? ~s[1] : (c[1] ? s[1] : ~s[1]));
        w[2] = c[2] & (deep ? ~s[2] : (c[3] ? s[2] : ~s[2]));
        w[3] = c[4] & ~deep & (c[5] ? s[3] : ~s[3]);
        w[4] = tick_on & s[4];
        return w;
    endfunction

    assign wake_req = wake_set(stop_deep, st_q.cfg[5:0], |st_q.tsel, syn_w);
    assign wake_now = wake_set(st_q.mode == M_DEEP, st_q.cfg[5:0], |st_q.tsel, syn_w);
    assign first    = wake_now & (~wake_now + 1'b1);
    assign ack_wr   = wr_en && (wr_addr == A_ACK) && wr_data[0];

    always_comb begin
        st_d      = st_q;
        st_d.vrst = 1'b0;
        st_d.virq = 1'b0;
        st_d.vsrc = V_NONE;
        capture   = 1'b0;

        if (wr_en && wr_addr == A_CFG)  st_d.cfg  = wr_data;
        if (wr_en && wr_addr == A_TICK) st_d.tsel = wr_data[TSEL_W-1:0];
        if (ack_wr)                     st_d.flag = 1'b0;

        case (st_q.mode)
            M_RUN: begin
                if (stop_req && wake_req == '0) begin
                    st_d.mode = stop_deep ? M_DEEP : M_SHALLOW;
                    capture   = stop_deep;
                end
            end
            M_SHALLOW, M_DEEP: begin
                if (wake_now != '0) begin
                    st_d.mode = M_RUN;
                    st_d.src  = first;
                    if (st_q.mode == M_DEEP || first[0]) begin
                        st_d.vrst = 1'b1;
                        if (st_q.mode == M_DEEP) st_d.flag = 1'b1;
                    end else begin
                        st_d.virq = 1'b1;
                        st_d.vsrc = first[1] ? V_IRQ :
                                    first[2] ? V_KB1 :
                                    first[3] ? V_KB2 : V_TICK;
                    end
                end
            end
            default: st_d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    stopctl_pinhold #(.W(PINS)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(capture), .release_i(ack_wr),
        .pin_in(pin_in), .pin_out(pin_out), .hold(pin_hold)
    );

    assign clk_halt    = (st_q.mode != M_RUN);
    assign reg_standby = (st_q.mode != M_RUN);
    assign vec_reset   = st_q.vrst;
    assign periph_rst  = st_q.vrst;
    assign vec_irq     = st_q.virq;
    assign vec_src     = st_q.vsrc;

    always_comb begin
        case (rd_addr)
            A_CFG:   rd_data = st_q.cfg;
            A_TICK:  rd_data = {{(DW-TSEL_W){1'b0}}, st_q.tsel};
            A_STAT:  rd_data = {{(DW-NSRC-1){1'b0}}, st_q.src, st_q.flag};
            default: rd_data = '0;
        endcase
    end

    // R2: the latch only opens on an acknowledge write
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hold && !ack_wr) |=> pin_hold);
    // R1: frozen pins do not move while the latch stays closed
    a_r1_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hold && !ack_wr) |=> $stable(pin_out));
    // R4: without a deep-mode source the deep mode is kept
    a_r4_deep_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_DEEP && wake_now == '0) |=> (clk_halt && !vec_reset && !vec_irq));
    // R5: deep exit is always a reset-style restart with the flag set
    a_r5_deep_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_DEEP && wake_now != '0) |=> (vec_reset && periph_rst && !vec_irq && st_q.flag && pin_hold));
    // R6: reset vector and interrupt vector never requested together
    a_r6_vec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_reset && vec_irq));
    // R10: a request met by an active source does not halt
    a_r10_abort_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && stop_req && wake_req != '0) |=> (!clk_halt && !vec_irq && !vec_reset));
endmodule

// File: tb/stopctl_top_test.sv
module stopctl_top_test;
    localparam int CLK_P = 10;
    localparam int PINS  = 8;

    logic clk = 1'b0;
    logic rst_n, stop_req, stop_deep, rst_pin_n, irq_pin, kb1_pin, kb2_pin, tick_pulse;
    logic [PINS-1:0] pin_in, pin_out;
    logic pin_hold, wr_en, clk_halt, reg_standby, vec_reset, periph_rst, vec_irq;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [2:0] vec_src;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    stopctl_top #(.PINS(PINS)) uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_deep(stop_deep),
        .rst_pin_n(rst_pin_n), .irq_pin(irq_pin), .kb1_pin(kb1_pin), .kb2_pin(kb2_pin),
        .tick_pulse(tick_pulse), .pin_in(pin_in), .pin_out(pin_out), .pin_hold(pin_hold),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .clk_halt(clk_halt), .reg_standby(reg_standby),
        .vec_reset(vec_reset), .periph_rst(periph_rst), .vec_irq(vec_irq), .vec_src(vec_src)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic enter(input logic deep);
        stop_req = 1'b1; stop_deep = deep;
        step(1);
        stop_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R11", "clk_halt", clk_halt, 0);
        check("R11", "pin_hold", pin_hold, 0);
        check("R11", "vectors", {vec_reset, periph_rst, vec_irq}, 0);
        rd(2'd3, v); check("R11", "status", v, 0);
        rd(2'd0, v); check("R11", "cfg", v, 0);
    endtask

    task automatic t_shallow_irq;
        logic [7:0] v;
        wr(2'd0, 8'h03);
        irq_pin = 0; kb1_pin = 0; kb2_pin = 0;
        step(3);
        enter(1'b0);
        check("R3", "clk_halt", clk_halt, 1);
        check("R3", "reg_standby", reg_standby, 1);
        check("R3", "pin_hold shallow", pin_hold, 0);
        irq_pin = 1;
        step(2);
        check("R8", "still halted after two edges", clk_halt, 1);
        step(1);
        check("R6", "vec_irq", vec_irq, 1);
        check("R6", "vec_src irq", vec_src, 1);
        check("R6", "no reset", vec_reset, 0);
        check("R3", "clk released", clk_halt, 0);
        step(1);
        check("R6", "vec_irq one cycle", vec_irq, 0);
        rd(2'd3, v); check("R9", "status irq", v, 8'h04);
        irq_pin = 0; step(3);
    endtask

    task automatic t_shallow_kb2_rst;
        logic [7:0] v;
        wr(2'd0, 8'h10);
        kb2_pin = 1; step(3);
        enter(1'b0);
        kb2_pin = 0; step(3);
        check("R6", "vec_irq kb2", vec_irq, 1);
        check("R6", "vec_src kb2", vec_src, 3);
        rd(2'd3, v); check("R9", "status kb2", v, 8'h10);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R9", "status write ignored", v, 8'h10);
        kb2_pin = 1; step(3);
        enter(1'b0);
        rst_pin_n = 0; step(3);
        check("R6", "reset pin exit", {vec_reset, periph_rst, vec_irq}, 3'b110);
        rst_pin_n = 1; step(3);
        rd(2'd3, v); check("R9", "status reset pin", v, 8'h02);
    endtask

    task automatic t_priority;
        wr(2'd0, 8'h0F);
        irq_pin = 0; kb1_pin = 0; step(3);
        enter(1'b0);
        irq_pin = 1; kb1_pin = 1; step(3);
        check("R6", "priority irq over kb1", vec_src, 1);
        irq_pin = 0; kb1_pin = 0; step(3);
    endtask

    task automatic t_deep;
        logic [7:0] v;
        wr(2'd0, 8'h33);
        irq_pin = 1; kb1_pin = 1; kb2_pin = 0; pin_in = 8'hA5;
        step(3);
        enter(1'b1);
        check("R1", "pin_hold", pin_hold, 1);
        check("R3", "deep clk_halt", clk_halt, 1);
        check("R1", "pin_out captured", pin_out, 8'hA5);
        pin_in = 8'h5A; step(1);
        check("R1", "pin_out frozen", pin_out, 8'hA5);
        kb2_pin = 1; step(4);
        check("R4", "kb2 ignored in deep", clk_halt, 1);
        irq_pin = 0; step(3);
        check("R4", "irq active low wake", clk_halt, 0);
        check("R5", "reset pair", {vec_reset, periph_rst, vec_irq}, 3'b110);
        rd(2'd3, v); check("R5", "flag and source", v, 8'h05);
        check("R5", "pins still held", {pin_hold, pin_out}, {1'b1, 8'hA5});
        irq_pin = 1; kb2_pin = 0; step(3);
        wr(2'd2, 8'h00);
        check("R2", "zero write keeps hold", pin_hold, 1);
        wr(2'd2, 8'h01);
        check("R2", "ack opens latch", {pin_hold, pin_out}, {1'b0, 8'h5A});
        rd(2'd3, v); check("R2", "flag cleared", v, 8'h04);
        rd(2'd2, v); check("R2", "ack reads zero", v, 0);
    endtask

    task automatic t_tick;
        logic [7:0] v;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        enter(1'b0);
        tick_pulse = 1; step(1); tick_pulse = 0; step(5);
        check("R7", "tick off no wake", clk_halt, 1);
        rst_pin_n = 0; step(3);
        check("R7", "left via reset pin", vec_reset, 1);
        rst_pin_n = 1; step(3);
        wr(2'd1, 8'h03);
        rd(2'd1, v); check("R7", "rate readback", v, 8'h03);
        enter(1'b1);
        tick_pulse = 1; step(1); tick_pulse = 0; step(2);
        check("R7", "tick wakes deep", {vec_reset, clk_halt}, 2'b10);
        rd(2'd3, v); check("R9", "status tick", v, 8'h21);
        wr(2'd2, 8'h01); wr(2'd1, 8'h00);
    endtask

    task automatic t_abort;
        wr(2'd0, 8'h03);
        irq_pin = 1; step(3);
        enter(1'b0);
        check("R10", "shallow abort", {clk_halt, vec_irq, vec_reset}, 0);
        irq_pin = 0; step(3);
        enter(1'b1);
        check("R10", "deep abort", {clk_halt, pin_hold, vec_reset}, 0);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        rst_n = 0; stop_req = 0; stop_deep = 0; rst_pin_n = 1; irq_pin = 0;
        kb1_pin = 0; kb2_pin = 0; tick_pulse = 0; pin_in = '0;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        step(3);
        t_reset();
        rst_n = 1;
        step(3);
        t_shallow_irq();
        t_shallow_kb2_rst();
        t_priority();
        t_deep();
        t_tick();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule